// File: doc/BRIEF.md
# Interrupt Control Unit

This unit sits between a small processor core and three local event sources: one external pin whose active edge is chosen in software, a group of upper port pins watched for any change of level, and a one-cycle overflow pulse from a timer. Each source owns a sticky flag and an enable bit. A global enable gates the request line to the core. Flags record events even when nothing is enabled, so software can poll them.

The core presents an instruction-boundary strobe together with its current program counter. When a request is pending at a boundary, the unit takes the interrupt. It saves that program counter, drops the global enable and signals the core to fetch from the fixed service vector. A return strobe from the core sets the global enable again, and the saved address is held on an output for the core to resume from. A flag that the service routine left set raises the request again at once. Software reaches three registers through a small address/data bus. Writes take effect at the clock edge and read data appears one cycle after the read strobe.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the control and option registers read 0x00, `irq_req`, `irq_take` and `ret_pc` are 0, and `vec_addr` is 0x004.
- R2: With option register (address 1) bit 6 at 1, a low-to-high change of `ext_pin` sets the external flag (control bit 1), and a high-to-low change does not.
- R3: With option bit 6 at 0, a high-to-low change of `ext_pin` sets the external flag, and a low-to-high change does not.
- R4: A read of address 2 returns the synchronized port pins in its low bits and loads them into a reference latch. While the pins differ from the latch, the change flag (control bit 0) is set, so clearing it has no lasting effect. After a port read and a clear, it stays 0.
- R5: A one-cycle `tmr_ovf` pulse sets the timer flag (control bit 2).
- R6: Flags are set by their events while the local enables (control bits 6 timer, 5 external, 4 change) and the global enable (control bit 7) are 0, and `irq_req` then stays 0.
- R7: `irq_req` is 1 exactly when the global enable is 1 and some source has both its flag and its enable set.
- R8: When `insn_boundary` is 1 with `irq_req` at 1, the next cycle shows `irq_take` high for one cycle, a cleared global enable, and `ret_pc` equal to the `pc_in` presented at that boundary. `vec_addr` stays 0x004.
- R9: A `ret_strobe` sets the global enable, and `ret_pc` still holds the address saved at entry. A flag left set with its enable on makes `irq_req` 1 in the next cycle.
- R10: If a control write clears a flag in the same cycle that its event occurs, the flag ends up set.
- R11: An event during service (global enable 0) sets its flag without raising `irq_req`. The request appears after the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 option, 2 port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_re` |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | PORT_W | Watched port pins, asynchronous |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| pc_in | input | PC_W | Program counter to save on entry |
| ret_strobe | input | 1 | Core executes return-from-interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_take | output | 1 | One-cycle pulse: entry taken, fetch from `vec_addr` |
| vec_addr | output | PC_W | Fixed service vector |
| ret_pc | output | PC_W | Address saved at the latest entry |

## Verification
The bench builds the unit with its default parameters: a 13-bit program counter, four watched port pins, a two-stage synchronizer and vector 0x004. With these values the full 8-bit register layout is in play, including the port read path zero-extended above four pins. The synchronizer delay is short, so each edge and mismatch case can be placed cycle-exactly next to bus writes. That makes the same-cycle collision between a hardware set and a software clear, and the entry and return handshake with a leftover flag, reachable in a short directed sequence.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int DATA_W = 8;

    // control register layout
    localparam int GIE_BIT   = 7;
    localparam int EN_LSB    = 4;
    localparam int FLAG_LSB  = 0;
    // option register
    localparam int EDGE_BIT  = 6;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_OPT  = 2'd1,
        REG_PORT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // one bit per source; tmr is the MSB, chg the LSB
    typedef struct packed {
        logic tmr;
        logic ext;
        logic chg;
    } src_t;

    localparam int NSRC = $bits(src_t);

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic gie,
                                                    input src_t en,
                                                    input src_t flg);
        logic [DATA_W-1:0] v;
        v = '0;
        v[GIE_BIT] = gie;
        v[EN_LSB +: NSRC] = en;
        v[FLAG_LSB +: NSRC] = flg;
        return v;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[k] <= '0;
                    else     stage[k] <= stage[k-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect
    import irq_ctrl_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_s,
    input  logic [PORT_W-1:0] port_s,
    input  logic              tmr_ovf,
    input  logic              edge_rise,
    input  logic              latch_load,
    output src_t              ev
);
    logic              ext_prev;
    logic [PORT_W-1:0] port_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev <= 1'b0;
            port_ref <= '0;
        end else begin
            ext_prev <= ext_s;
            if (latch_load) port_ref <= port_s;
        end
    end

    always_comb begin
        ev.tmr = tmr_ovf;
        ev.ext = edge_rise ? (ext_s & ~ext_prev) : (~ext_s & ext_prev);
        ev.chg = (port_s != port_ref);
    end

    // R2: in rising mode two edge events can never be back to back
    p_edge_single_r2: assert property (@(posedge clk) disable iff (rst)
        (ev.ext && edge_rise) |=> !(ev.ext && edge_rise));

    // R4: after loading the latch with unchanged pins there is no mismatch
    p_latch_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        latch_load |=> ($stable(port_s) -> !ev.chg));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_ctrl_pkg::*;
#(
    parameter int PC_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_opt,
    input  logic [DATA_W-1:0] wdata,
    input  src_t              ev,
    input  logic              insn_boundary,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              ret_strobe,
    output logic              gie,
    output src_t              en,
    output src_t              flags,
    output logic              edge_rise,
    output logic              irq_req,
    output logic              irq_take,
    output logic [PC_W-1:0]   saved_pc
);
    logic entry;
    src_t flag_base;

    assign irq_req = gie && ((flags & en) != '0);
    assign entry   = insn_boundary && irq_req;

    // software value first, then events OR in: a set always wins
    always_comb begin
        flag_base = wr_ctrl ? src_t'(wdata[FLAG_LSB +: NSRC]) : flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gie       <= 1'b0;
            en        <= '0;
            flags     <= '0;
            edge_rise <= 1'b0;
            irq_take  <= 1'b0;
            saved_pc  <= '0;
        end else begin
            flags    <= flag_base | ev;
            irq_take <= entry;
            if (wr_ctrl) en <= src_t'(wdata[EN_LSB +: NSRC]);
            if (wr_opt)  edge_rise <= wdata[EDGE_BIT];
            if (entry)   saved_pc <= pc_in;
            if (entry)           gie <= 1'b0;
            else if (ret_strobe) gie <= 1'b1;
            else if (wr_ctrl)    gie <= wdata[GIE_BIT];
        end
    end

    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_flag_chk
            // R6: an event sets its flag regardless of any enable
            p_event_sets_r6: assert property (@(posedge clk) disable iff (rst)
                ev[i] |=> flags[i]);
            // R10: a clearing write in the event cycle does not win
            p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
                (ev[i] && wr_ctrl && !wdata[FLAG_LSB + i]) |=> flags[i]);
            // R4: without a write a flag cannot drop
            p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
                (flags[i] && !wr_ctrl) |=> flags[i]);
        end
    endgenerate

    // R8: entry pulse follows an enabled boundary and leaves gie clear
    p_take_clears_r8: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (!gie && $past(gie)));
    // R8: the saved address only moves on an entry
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !irq_take |-> $stable(saved_pc));
    // R9: return restores gie unless an entry happens in the same cycle
    p_ret_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (ret_strobe && !entry) |=> gie);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int PC_W        = 13,
    parameter int PORT_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int VEC_ADDR    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              tmr_ovf,
    input  logic              insn_boundary,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              ret_strobe,
    output logic              irq_req,
    output logic              irq_take,
    output logic [PC_W-1:0]   vec_addr,
    output logic [PC_W-1:0]   ret_pc
);
    localparam int SYNC_W = PORT_W + 1;
    localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

    reg_sel_e          sel;
    logic              wr_ctrl, wr_opt, port_rd;
    logic [SYNC_W-1:0] pins_s;
    logic              ext_s;
    logic [PORT_W-1:0] port_s;
    src_t              ev, en, flags;
    logic              gie, edge_rise;
    logic [DATA_W-1:0] rd_mux;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_ctrl = bus_we && (sel == REG_CTRL);
    assign wr_opt  = bus_we && (sel == REG_OPT);
    assign port_rd = bus_re && (sel == REG_PORT);

    irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ext_pin, port_pins}),
        .q   (pins_s)
    );
    assign ext_s  = pins_s[SYNC_W-1];
    assign port_s = pins_s[PORT_W-1:0];

    irq_detect #(.PORT_W(PORT_W)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .ext_s      (ext_s),
        .port_s     (port_s),
        .tmr_ovf    (tmr_ovf),
        .edge_rise  (edge_rise),
        .latch_load (port_rd),
        .ev         (ev)
    );

    irq_regs #(.PC_W(PC_W)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_ctrl       (wr_ctrl),
        .wr_opt        (wr_opt),
        .wdata         (bus_wdata),
        .ev            (ev),
        .insn_boundary (insn_boundary),
        .pc_in         (pc_in),
        .ret_strobe    (ret_strobe),
        .gie           (gie),
        .en            (en),
        .flags         (flags),
        .edge_rise     (edge_rise),
        .irq_req       (irq_req),
        .irq_take      (irq_take),
        .saved_pc      (ret_pc)
    );

    always_comb begin
        unique case (sel)
            REG_CTRL: rd_mux = pack_ctrl(gie, en, flags);
            REG_OPT:  begin
                rd_mux = '0;
                rd_mux[EDGE_BIT] = edge_rise;
            end
            REG_PORT: rd_mux = DATA_W'(port_s);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    assign vec_addr = VEC;

    // R7: no request can be pending across a cleared global enable
    p_req_gated_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(u_regs.gie) |-> !irq_req);
    // R11: a request raised right after a return comes from a set flag
    p_req_after_ret_r11: assert property (@(posedge clk) disable iff (rst)
        (ret_strobe && !irq_req && ((flags & en) != '0)) |=> irq_req);
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
    localparam int PC_W = 13;
    localparam int PORT_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0, bus_re = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              ext_pin = 1'b0;
    logic [PORT_W-1:0] port_pins = '0;
    logic              tmr_ovf = 1'b0;
    logic              insn_boundary = 1'b0;
    logic [PC_W-1:0]   pc_in = '0;
    logic              ret_strobe = 1'b0;
    logic              irq_req, irq_take;
    logic [PC_W-1:0]   vec_addr, ret_pc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t exp_q[$];
    logic re_d = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pin(ext_pin), .port_pins(port_pins), .tmr_ovf(tmr_ovf),
        .insn_boundary(insn_boundary), .pc_in(pc_in), .ret_strobe(ret_strobe),
        .irq_req(irq_req), .irq_take(irq_take), .vec_addr(vec_addr),
        .ret_pc(ret_pc)
    );

    // monitor: read data is valid the cycle after the strobe
    always @(posedge clk) re_d <= bus_re;
    always @(negedge clk) begin
        if (re_d && exp_q.size() > 0) begin
            rd_item_t it;
            it = exp_q.pop_front();
            total++;
            if (bus_rdata !== it.exp) begin
                bad++;
                $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_tmr();
        tmr_ovf = 1'b1;
        @(negedge clk);
        tmr_ovf = 1'b0;
    endtask

    task automatic enter(input logic [PC_W-1:0] pc);
        pc_in = pc; insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_req", irq_req, 0);
        chk("R1 irq_take", irq_take, 0);
        chk("R1 ret_pc", ret_pc, 0);
        chk("R1 vec_addr", vec_addr, 13'h004);
        rd(2'd0, 8'h00, "R1 ctrl");
        rd(2'd1, 8'h00, "R1 opt");

        // R5 / R6 timer flag with everything disabled
        pulse_tmr();
        idle(2);
        chk("R6 no request", irq_req, 0);
        rd(2'd0, 8'h04, "R5 timer flag");

        // R2 rising mode
        wr(2'd1, 8'h40);
        rd(2'd1, 8'h40, "R2 option bit");
        ext_pin = 1'b1; idle(4);
        rd(2'd0, 8'h06, "R2 rising sets");
        wr(2'd0, 8'h00);
        ext_pin = 1'b0; idle(4);
        rd(2'd0, 8'h00, "R2 falling ignored");

        // R3 falling mode
        wr(2'd1, 8'h00);
        ext_pin = 1'b1; idle(4);
        rd(2'd0, 8'h00, "R3 rising ignored");
        ext_pin = 1'b0; idle(4);
        rd(2'd0, 8'h02, "R3 falling sets");
        wr(2'd0, 8'h00);

        // R4 port change with reference latch
        port_pins = 4'b0101; idle(4);
        rd(2'd0, 8'h01, "R4 mismatch sets");
        wr(2'd0, 8'h00); idle(2);
        rd(2'd0, 8'h01, "R4 clear ineffective");
        rd(2'd2, 8'h05, "R4 port read");
        wr(2'd0, 8'h00); idle(2);
        rd(2'd0, 8'h00, "R4 stays clear");

        // R7 request gating
        wr(2'd0, 8'h40);
        pulse_tmr(); idle(2);
        chk("R7 gie off", irq_req, 0);
        wr(2'd0, 8'hC4);
        chk("R7 gie on", irq_req, 1);

        // R8 entry
        enter(13'h0123);
        chk("R8 take", irq_take, 1);
        chk("R8 req dropped", irq_req, 0);
        chk("R8 saved pc", ret_pc, 13'h0123);
        chk("R8 vector", vec_addr, 13'h004);
        @(negedge clk);
        chk("R8 take one cycle", irq_take, 0);
        rd(2'd0, 8'h44, "R8 gie cleared");

        // R11 event during service
        wr(2'd0, 8'h60);
        wr(2'd1, 8'h40);
        ext_pin = 1'b1; idle(4);
        chk("R11 no request in service", irq_req, 0);
        rd(2'd0, 8'h62, "R11 flag recorded");

        // R9 return with leftover flag
        ret_strobe = 1'b1;
        @(negedge clk);
        ret_strobe = 1'b0;
        chk("R9 re-request", irq_req, 1);
        chk("R9 ret_pc", ret_pc, 13'h0123);
        rd(2'd0, 8'hE2, "R9 gie restored");
        enter(13'h0456);
        chk("R9 second take", irq_take, 1);
        chk("R8 new saved pc", ret_pc, 13'h0456);
        idle(1);

        // R10 set wins over clear
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h40; tmr_ovf = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tmr_ovf = 1'b0;
        idle(1);
        rd(2'd0, 8'h44, "R10 set wins");

        idle(2);
        chk("queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule